// File: doc/BRIEF.md
# In-Place Byte Sorter

This block reorders, in place, the bytes held in an external single-port RAM that has one cycle of synchronous read latency. The user steps through four orderings with an up-button pulse and then pulses start. From that point the block owns the RAM port. It makes repeated bubble passes over the whole address range. Each pass reads two neighbouring bytes in two cycles, decides in a third cycle whether they are out of order, and when they are, writes them back exchanged in two consecutive cycles.

The comparison rule is chosen at run time. A byte is read either as unsigned or as two's complement, and the result is either ascending or descending. The ordering is captured when start is accepted, so the mode register can be changed between runs without affecting a sort already under way. The run ends after the first pass that makes no exchange. A one-cycle done pulse then marks completion, and the RAM holds a reordered copy of what it held before.

Top module: `byte_sorter`

## Requirements
- R1: After synchronous reset, busy, done and mem_we are 0 and the selected ordering is 0.
- R2: While idle, each mode_up pulse advances the ordering 0→1→2→3→0. The encoding is 0 = signed descending, 1 = signed ascending, 2 = unsigned descending and 3 = unsigned ascending.
- R3: mode_up and start have no effect while busy. The ordering used for a sort is the one latched when start was accepted. If mode_up and start arrive in the same idle cycle, start wins and the mode does not advance.
- R4: A start pulse while idle raises busy in the next cycle, and the sort covers every address of the RAM.
- R5: In ordering 1, the final contents ascend as two's complement values, so 0x80..0xFF come before 0x00..0x7F.
- R6: In ordering 0, the final contents descend as two's complement values.
- R7: In orderings 2 and 3, the final contents descend or ascend, respectively, as unsigned values.
- R8: mem_we is asserted only while busy. Writes come in pairs on two consecutive cycles, and the second write of a pair goes to the address one above the first. A fully reversed array of N distinct values therefore costs N(N-1) write cycles.
- R9: Equal neighbours are never exchanged. An input that is already in order, or whose bytes are all equal, produces no write at all.
- R10: done is high for exactly one cycle, with busy low, when the sort finishes. The final contents are a permutation of the starting contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_up | input | 1 | One-cycle pulse that advances the ordering |
| start | input | 1 | One-cycle pulse that starts a sort |
| mode | output | 2 | Currently selected ordering |
| busy | output | 1 | High while a sort is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | RAM address |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |

## Verification
The assertions assume that the RAM returns the data for an address exactly one cycle after that address is presented, and that the RAM changes only through this block's write port while busy is high. They also assume that reset is held for at least one clock, so that every $past value comes from a reset state. The bench keeps to these assumptions: its RAM model is a registered read with the same latency, and it loads RAM contents only while busy is low. It drives mode_up and start as single-cycle pulses on the falling edge, including pulses aimed at a running sort to show that they are ignored.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [1:0] {
        ORD_S_DESC = 2'd0,
        ORD_S_ASC  = 2'd1,
        ORD_U_DESC = 2'd2,
        ORD_U_ASC  = 2'd3
    } order_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CMP,
        ST_WR_A,
        ST_WR_B,
        ST_FIN
    } state_e;

    function automatic logic ord_is_unsigned(order_e o);
        return o[1];
    endfunction

    function automatic logic ord_is_ascending(order_e o);
        return o[0];
    endfunction

    function automatic order_e ord_next(order_e o);
        return order_e'(o + 2'd1);
    endfunction

endpackage

// File: rtl/order_select.sv
module order_select
    import sorter_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mode_up,
    input  logic   start,
    input  logic   busy_i,
    output order_e mode_o
);

    order_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ORD_S_DESC;
        end else if (mode_up && !busy_i && !start) begin
            mode_q <= ord_next(mode_q);
        end
    end

    assign mode_o = mode_q;

    // R3: the selection is frozen for the whole run
    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(mode_q));

    // R2: an idle press moves one step with wrap-around
    a_r2_mode_step: assert property (@(posedge clk) disable iff (rst)
        (mode_up && !busy_i && !start) |=> (mode_q == order_e'($past(mode_q) + 2'd1)));

endmodule

// File: rtl/pair_compare.sv
module pair_compare
    import sorter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lower_i,
    input  logic [DATA_W-1:0] upper_i,
    input  order_e            ord_i,
    output logic              swap_o
);

    logic              flip;
    logic [DATA_W-1:0] key_lo;
    logic [DATA_W-1:0] key_up;

    // Inverting the sign bit maps two's complement order onto unsigned order.
    assign flip   = ~ord_is_unsigned(ord_i);
    assign key_lo = {lower_i[DATA_W-1] ^ flip, lower_i[DATA_W-2:0]};
    assign key_up = {upper_i[DATA_W-1] ^ flip, upper_i[DATA_W-2:0]};

    always_comb begin
        if (ord_is_ascending(ord_i)) begin
            swap_o = key_lo > key_up;
        end else begin
            swap_o = key_lo < key_up;
        end
    end

    // R9: identical bytes never ask for an exchange
    always_comb begin
        if (lower_i == upper_i) begin
            a_r9_equal_kept: assert (!swap_o);
        end
    end

endmodule

// File: rtl/sort_sequencer.sv
module sort_sequencer
    import sorter_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  order_e            sel_i,
    input  logic              swap_i,
    output order_e            ord_o,
    output logic [DATA_W-1:0] lower_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);

    localparam int              DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 2);

    state_e            state;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] lower_q;
    logic [DATA_W-1:0] upper_q;
    logic              dirty;
    order_e            ord_q;
    logic              at_last;

    assign at_last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            lower_q <= '0;
            upper_q <= '0;
            dirty   <= 1'b0;
            ord_q   <= ORD_S_DESC;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ord_q <= sel_i;
                        idx   <= '0;
                        dirty <= 1'b0;
                        state <= ST_RD_A;
                    end
                end
                ST_RD_A: state <= ST_RD_B;
                ST_RD_B: begin
                    lower_q <= mem_rdata;
                    state   <= ST_CMP;
                end
                ST_CMP: begin
                    upper_q <= mem_rdata;
                    if (swap_i) begin
                        state <= ST_WR_A;
                    end else if (!at_last) begin
                        idx   <= idx + 1'b1;
                        state <= ST_RD_A;
                    end else if (dirty) begin
                        idx   <= '0;
                        dirty <= 1'b0;
                        state <= ST_RD_A;
                    end else begin
                        state <= ST_FIN;
                    end
                end
                ST_WR_A: state <= ST_WR_B;
                ST_WR_B: begin
                    state <= ST_RD_A;
                    if (at_last) begin
                        idx   <= '0;
                        dirty <= 1'b0;
                    end else begin
                        idx   <= idx + 1'b1;
                        dirty <= 1'b1;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_RD_B, ST_WR_B: mem_addr = idx + 1'b1;
            default:          mem_addr = idx;
        endcase
    end

    assign mem_we    = (state == ST_WR_A) || (state == ST_WR_B);
    assign mem_wdata = (state == ST_WR_A) ? upper_q : lower_q;
    assign busy_o    = (state != ST_IDLE) && (state != ST_FIN);
    assign done_o    = (state == ST_FIN);
    assign ord_o     = ord_q;
    assign lower_o   = lower_q;

    // R8: the RAM is written only during a run
    a_r8_we_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy_o);

    // R8: the first write of a pair is always followed by a second
    a_r8_pair_open: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(mem_we)) |=> mem_we);

    // R8: a pair never grows to three writes
    a_r8_pair_close: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we);

    // R8: the second write lands one address above the first
    a_r8_pair_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R10: completion is a single cycle and never overlaps busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R3: the ordering in use does not change during a run
    a_r3_order_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (ord_q == $past(ord_q)));

endmodule

// File: rtl/byte_sorter.sv
module byte_sorter
    import sorter_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_up,
    input  logic              start,
    output logic [1:0]        mode,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);

    order_e            sel;
    order_e            ord_run;
    logic              swap;
    logic [DATA_W-1:0] lower;

    order_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .mode_up (mode_up),
        .start   (start),
        .busy_i  (busy),
        .mode_o  (sel)
    );

    pair_compare #(.DATA_W(DATA_W)) u_cmp (
        .lower_i (lower),
        .upper_i (mem_rdata),
        .ord_i   (ord_run),
        .swap_o  (swap)
    );

    sort_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sel_i     (sel),
        .swap_i    (swap),
        .ord_o     (ord_run),
        .lower_o   (lower),
        .busy_o    (busy),
        .done_o    (done),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    assign mode = sel;

endmodule

// File: tb/sim_byte_sorter.sv
module sim_byte_sorter;

    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int NV = 8;
    // each entry: {ordering, LFSR seed}
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'h1D}, {2'd1, 8'hA7}, {2'd2, 8'h5C}, {2'd3, 8'h33},
        {2'd3, 8'hE1}, {2'd2, 8'h09}, {2'd1, 8'h7E}, {2'd0, 8'hC4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_up = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode;
    logic          busy, done, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata, mem_wdata;

    logic [7:0] ram [N];
    logic [7:0] expv [N];
    int checks = 0, fails = 0, wr_cnt = 0, done_cnt = 0;
    bit timed_out = 0;

    always #10 clk = ~clk;

    byte_sorter #(.ADDR_W(AW), .DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .mode_up(mode_up), .start(start), .mode(mode),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    always @(negedge clk) begin
        if (mem_we === 1'b1) wr_cnt++;
        if (done === 1'b1) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] m);
        if (m == 2'd0) return "R6";
        if (m == 2'd1) return "R5";
        return "R7";
    endfunction

    function automatic logic [7:0] key_of(input logic [7:0] v, input logic [1:0] m);
        return m[1] ? v : (v ^ 8'h80);
    endfunction

    task automatic fill_lfsr(input logic [7:0] seed);
        logic [7:0] v = (seed == 0) ? 8'h01 : seed;
        for (int k = 0; k < N; k++) begin
            ram[k] = v;
            v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
        end
    endtask

    // reference: selection sort on the mapped keys
    task automatic build_expected(input logic [1:0] m);
        for (int k = 0; k < N; k++) expv[k] = ram[k];
        for (int i = 0; i < N - 1; i++) begin
            int best = i;
            for (int j = i + 1; j < N; j++) begin
                if (m[0] ? (key_of(expv[j], m) < key_of(expv[best], m))
                         : (key_of(expv[j], m) > key_of(expv[best], m)))
                    best = j;
            end
            begin
                logic [7:0] t = expv[i];
                expv[i] = expv[best];
                expv[best] = t;
            end
        end
    endtask

    task automatic press_up();
        @(negedge clk) mode_up = 1'b1;
        @(negedge clk) mode_up = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        for (int k = 0; k < 4 && mode != m; k++) press_up();
    endtask

    task automatic kick();
        wr_cnt = 0;
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy === 1'b1, "R4 busy after start", busy, 1);
    endtask

    task automatic wait_finish();
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            timed_out = 1;
            chk(0, "R10 done never seen", 0, 1);
        end else begin
            chk(busy === 1'b0, "R10 busy low with done", busy, 0);
            @(negedge clk);
            chk(done === 1'b0, "R10 done one cycle", done, 0);
        end
    endtask

    task automatic compare_all(input string req);
        int bad = 0, first = -1;
        for (int k = 0; k < N; k++)
            if (ram[k] !== expv[k]) begin
                bad++;
                if (first < 0) first = k;
            end
        if (first < 0) chk(1, req, 0, 0);
        else chk(0, req, ram[first], expv[first]);
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) ram[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0, "R1 outputs idle", {busy, done, mem_we}, 0);
        chk(mode === 2'd0, "R1 mode zero", mode, 0);

        // R2 stepping with wrap
        for (int k = 1; k <= 4; k++) begin
            press_up();
            chk(mode === 2'(k % 4), "R2 mode step", mode, k % 4);
        end

        // table walk: every ordering twice
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m = VEC[v][9:8];
            fill_lfsr(VEC[v][7:0]);
            build_expected(m);
            set_mode(m);
            kick();
            wait_finish();
            compare_all(req_of(m));
            chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        end

        // R9 already in order: no writes
        for (int k = 0; k < N; k++) ram[k] = 8'(k * 3);
        build_expected(2'd3);
        set_mode(2'd3);
        kick();
        wait_finish();
        chk(wr_cnt == 0, "R9 sorted input no writes", wr_cnt, 0);
        compare_all("R9 sorted input unchanged");

        // R9 all equal: no writes
        for (int k = 0; k < N; k++) ram[k] = 8'h5A;
        set_mode(2'd0);
        kick();
        wait_finish();
        chk(wr_cnt == 0, "R9 equal bytes no writes", wr_cnt, 0);

        // R5 sign boundary bytes
        for (int k = 0; k < N; k++) begin
            logic [7:0] pat [6] = '{8'h7F, 8'h80, 8'h00, 8'hFF, 8'h01, 8'h81};
            ram[k] = pat[k % 6];
        end
        build_expected(2'd1);
        set_mode(2'd1);
        kick();
        wait_finish();
        compare_all("R5 sign boundary");
        chk(ram[0] === 8'h80 && ram[N-1] === 8'h7F, "R5 ends", {ram[0], ram[N-1]}, 16'h807F);
        build_expected(2'd2);
        set_mode(2'd2);
        kick();
        wait_finish();
        compare_all("R7 unsigned boundary");

        // R8 reversed distinct values: N(N-1)/2 exchanges, two writes each
        for (int k = 0; k < N; k++) ram[k] = 8'(N - 1 - k);
        build_expected(2'd3);
        set_mode(2'd3);
        kick();
        wait_finish();
        chk(wr_cnt == N * (N - 1), "R8 write pairs", wr_cnt, N * (N - 1));
        compare_all("R8 reversed result");

        // R3 presses and start during a run are ignored
        fill_lfsr(8'h6B);
        build_expected(2'd2);
        set_mode(2'd2);
        kick();
        press_up();
        press_up();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(mode === 2'd2, "R3 mode frozen while busy", mode, 2);
        wait_finish();
        compare_all("R3 ordering latched");
        chk(done_cnt == 1, "R3 restart ignored", done_cnt, 1);

        // R3 start and up in one idle cycle: start wins
        fill_lfsr(8'h91);
        set_mode(2'd1);
        build_expected(2'd1);
        wr_cnt = 0;
        done_cnt = 0;
        @(negedge clk) begin start = 1'b1; mode_up = 1'b1; end
        @(negedge clk) begin start = 1'b0; mode_up = 1'b0; end
        chk(mode === 2'd1, "R3 up lost to start", mode, 1);
        wait_finish();
        compare_all("R3 same-cycle start result");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule